// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges four reset requests into a single active-high system reset: an active-low external pin, a supply-monitor "at or below threshold" indication, a comparator output, and a missing-clock event. The pin always acts as a reset source. Each of the other three sources must be enabled before it can reset the system. The supply monitor also needs a separate on/off control. Once every request has gone away, the system reset stays asserted for a fixed number of clock cycles.

Software uses a small register bus with two registers. In the reset-source register, some bits have two meanings. Writing a bit enables the matching source. Reading the same bit shows which source caused the most recent reset. The supply-monitor control register holds the monitor enable and shows the live supply status.

Top module: `reset_source_ctrl`

## Requirements
- R1: While `extRstN` is low, `sysRst` is high from the next rising clock edge. After a pin reset, bit 0 of register 0xEF reads 1.
- R2: Once every request is inactive, `sysRst` falls on the 16th rising edge at which no request is active. Without an active request, `sysRst` does not rise.
- R3: The cause flags are captured on the edge that starts a reset and held until the next reset starts. A source that becomes active during a reset does not change them.
- R4: At most one cause flag is set. On a simultaneous start, the priority is pin (bit 0), then supply (bit 1), then missing clock (bit 2), then comparator (bit 5). Bits 7, 6, 4 and 3 of 0xEF read 0.
- R5: Writing bit 2 of 0xEF enables the missing-clock source (1) or disables it (0). While it is disabled, `clkMissing` has no effect.
- R6: Writing bit 5 of 0xEF selects the comparator. While it is selected, `cmpOut` low requests a reset. While it is not selected, `cmpOut` is ignored.
- R7: `supplyLow` requests a reset only when both the monitor enable (0xFF bit 7) and the supply select (0xEF bit 1) are 1.
- R8: Register 0xFF reads bit 7 = monitor enable and bit 6 = NOT `supplyLow` (live). Bits 5..0 read 0, and writes to them have no effect. Any other address reads 0.
- R9: Register writes made while `sysRst` is high are ignored. The source enables keep their values across every reset other than power-on.
- R10: While `porN` is low, `sysRst` is high at once. After power-on, 0xEF reads 0x02, the monitor enable is 1, and the supply, missing-clock and comparator enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| extRstN | input | 1 | External reset pin level, active low |
| supplyLow | input | 1 | Supply monitor output, 1 = at or below threshold |
| cmpOut | input | 1 | Comparator output, 0 = non-inverting input below inverting input |
| clkMissing | input | 1 | Missing-clock detector event |
| regAddr | input | 8 | Register address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| sysRst | output | 1 | System reset, active high |

## Verification
An incorrect enable bit shows up at `sysRst` within two clock edges after the matching input is driven. The output either rises when it should not or stays low when it should rise. An incorrect cause flag or priority stays hidden until the reset ends, and then a single read of 0xEF shows it. The bench therefore reads the flags after every reset it causes. An error in the hold counter shifts the falling edge of `sysRst` by whole cycles, so the bench counts the high cycles exactly after the pin is released.

// File: rtl/rst_src_pkg.sv
package rst_src_pkg;
  // request / flag index order is also the capture priority (0 wins)
  localparam int SRC_N   = 4;
  localparam int IDX_PIN = 0;
  localparam int IDX_SUP = 1;
  localparam int IDX_MCD = 2;
  localparam int IDX_CMP = 3;

  // bit positions inside the reset-source register
  localparam int POS_PIN = 0;
  localparam int POS_SUP = 1;
  localparam int POS_MCD = 2;
  localparam int POS_CMP = 5;

  // bit positions inside the monitor control register
  localparam int POS_MON_EN = 7;
  localparam int POS_STAT   = 6;

  typedef struct packed {
    logic             capture;
    logic [SRC_N-1:0] winner;
  } rstStrobe_t;
endpackage

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
  import rst_src_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic             clk,
  input  logic             porN,
  input  logic [SRC_N-1:0] srcReq,
  output rstStrobe_t       strobe,
  output logic             sysRst
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYCLES);

  logic             inReset;
  logic [CNT_W-1:0] holdCnt;
  logic             anyReq;
  logic [SRC_N-1:0] winner;

  assign anyReq = |srcReq;

  // fixed priority: lowest index wins
  always_comb begin
    winner = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (srcReq[i]) winner = SRC_N'(1) << i;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      inReset <= 1'b1;
      holdCnt <= HOLD_LOAD;
    end else if (anyReq) begin
      inReset <= 1'b1;
      holdCnt <= HOLD_LOAD;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
      if (holdCnt == CNT_W'(1)) inReset <= 1'b0;
    end
  end

  assign strobe.capture = anyReq && !inReset;
  assign strobe.winner  = winner;
  assign sysRst         = inReset;
endmodule

// File: rtl/rst_src_regs.sv
module rst_src_regs
  import rst_src_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] SRC_ADDR = 'hEF,
  parameter logic [ADDR_W-1:0] MON_ADDR = 'hFF
) (
  input  logic              clk,
  input  logic              porN,
  input  rstStrobe_t        strobe,
  input  logic              sysRst,
  input  logic              extRstN,
  input  logic              supplyLow,
  input  logic              cmpOut,
  input  logic              clkMissing,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [SRC_N-1:0]  srcReq,
  output logic [SRC_N-1:0]  srcFlags
);
  logic monEn, supSel, mcdEn, cmpEn;
  logic wrSrc, wrMon;

  assign wrSrc = regWe && !sysRst && (regAddr == SRC_ADDR);
  assign wrMon = regWe && !sysRst && (regAddr == MON_ADDR);

  assign srcReq[IDX_PIN] = !extRstN;
  assign srcReq[IDX_SUP] = supplyLow && monEn && supSel;
  assign srcReq[IDX_MCD] = clkMissing && mcdEn;
  assign srcReq[IDX_CMP] = !cmpOut && cmpEn;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      monEn  <= 1'b1;
      supSel <= 1'b0;
      mcdEn  <= 1'b0;
      cmpEn  <= 1'b0;
    end else begin
      if (wrMon) monEn <= regWdata[POS_MON_EN];
      if (wrSrc) begin
        supSel <= regWdata[POS_SUP];
        mcdEn  <= regWdata[POS_MCD];
        cmpEn  <= regWdata[POS_CMP];
      end
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)               srcFlags <= SRC_N'(1) << IDX_SUP;
    else if (strobe.capture) srcFlags <= strobe.winner;
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == SRC_ADDR) begin
      regRdata[POS_PIN] = srcFlags[IDX_PIN];
      regRdata[POS_SUP] = srcFlags[IDX_SUP];
      regRdata[POS_MCD] = srcFlags[IDX_MCD];
      regRdata[POS_CMP] = srcFlags[IDX_CMP];
    end else if (regAddr == MON_ADDR) begin
      regRdata[POS_MON_EN] = monEn;
      regRdata[POS_STAT]   = !supplyLow;
    end
  end
endmodule

// File: rtl/reset_source_ctrl.sv
module reset_source_ctrl
  import rst_src_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              extRstN,
  input  logic              supplyLow,
  input  logic              cmpOut,
  input  logic              clkMissing,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              sysRst
);
  rstStrobe_t       strobe;
  logic [SRC_N-1:0] srcReq;
  logic [SRC_N-1:0] srcFlags;

  rst_src_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
    .clk    (clk),
    .porN   (porN),
    .srcReq (srcReq),
    .strobe (strobe),
    .sysRst (sysRst)
  );

  rst_src_regs #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SRC_ADDR(ADDR_W'('hEF)),
    .MON_ADDR(ADDR_W'('hFF))
  ) u_regs (
    .clk       (clk),
    .porN      (porN),
    .strobe    (strobe),
    .sysRst    (sysRst),
    .extRstN   (extRstN),
    .supplyLow (supplyLow),
    .cmpOut    (cmpOut),
    .clkMissing(clkMissing),
    .regAddr   (regAddr),
    .regWe     (regWe),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .srcReq    (srcReq),
    .srcFlags  (srcFlags)
  );
endmodule

// File: rtl/reset_source_ctrl_chk.sv
module reset_source_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              porN,
  input logic              extRstN,
  input logic              supplyLow,
  input logic              cmpOut,
  input logic              clkMissing,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regRdata,
  input logic              sysRst,
  input logic [3:0]        srcFlags
);
  AST_PIN_FORCES_RST: assert property (@(posedge clk) disable iff (!porN)
    !extRstN |=> sysRst); // R1

  AST_NO_SPURIOUS_RST: assert property (@(posedge clk) disable iff (!porN)
    (!sysRst && extRstN && !supplyLow && cmpOut && !clkMissing) |=> !sysRst); // R2

  AST_RELEASE_PIN_IDLE: assert property (@(posedge clk) disable iff (!porN)
    $fell(sysRst) |-> $past(extRstN)); // R2

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!porN)
    $past(sysRst) |-> $stable(srcFlags)); // R3

  AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (!porN)
    $onehot0(srcFlags)); // R4

  AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (!porN)
    (regAddr == ADDR_W'('hFF)) |-> (regRdata[6] == !supplyLow && regRdata[5:0] == '0)); // R8
endmodule

bind reset_source_ctrl reset_source_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .porN      (porN),
  .extRstN   (extRstN),
  .supplyLow (supplyLow),
  .cmpOut    (cmpOut),
  .clkMissing(clkMissing),
  .regAddr   (regAddr),
  .regRdata  (regRdata),
  .sysRst    (sysRst),
  .srcFlags  (srcFlags)
);

// File: tb/reset_source_ctrl_tb.sv
`timescale 1ns/1ps
module reset_source_ctrl_tb;
  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic       extRstN = 1'b1;
  logic       supplyLow = 1'b0;
  logic       cmpOut = 1'b1;
  logic       clkMissing = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic       regWe = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       sysRst;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  reset_source_ctrl u_dut (
    .clk(clk), .porN(porN), .extRstN(extRstN), .supplyLow(supplyLow),
    .cmpOut(cmpOut), .clkMissing(clkMissing), .regAddr(regAddr),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata), .sysRst(sysRst)
  );

  // {write addr, write data, read addr, expected read}
  localparam logic [31:0] VECS [4] = '{
    {8'hFF, 8'h3F, 8'hFF, 8'h40},  // R8 monitor off, low bits ignored
    {8'hFF, 8'hFF, 8'hFF, 8'hC0},  // R8 monitor on
    {8'hEF, 8'hFF, 8'hEF, 8'h02},  // R3 enables written, flags untouched
    {8'h10, 8'hAA, 8'h10, 8'h00}   // R8 unmapped address
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    tick();
    regWe = 1'b0;
  endtask

  task automatic regCheck(input string req, input logic [7:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    check(req, regRdata, exp);
  endtask

  task automatic waitRelease();
    for (int i = 0; i < 200; i++) begin
      if (!sysRst) break;
      tick();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int highCnt;
    // power-on
    repeat (3) tick();
    check("R10 sysRst during POR", {7'b0, sysRst}, 8'h01);
    porN = 1'b1;
    waitRelease();
    regCheck("R10 flags after POR", 8'hEF, 8'h02);
    regCheck("R10 monitor reg after POR", 8'hFF, 8'hC0);

    // table-driven register accesses
    for (int v = 0; v < 4; v++) begin
      regWrite(VECS[v][31:24], VECS[v][23:16]);
      regCheck("R8 vector read", VECS[v][15:8], VECS[v][7:0]);
    end

    // pin reset and hold length
    extRstN = 1'b0;
    tick();
    check("R1 pin asserts reset", {7'b0, sysRst}, 8'h01);
    tick();
    extRstN = 1'b1;
    highCnt = 0;
    for (int i = 0; i < 100; i++) begin
      tick();
      if (sysRst) highCnt++; else break;
    end
    // falls on 16th idle edge: 15 negedge samples still high
    check("R2 hold cycles", 8'(highCnt), 8'd15);
    regCheck("R1 pin flag", 8'hEF, 8'h01);

    // mid-reset source and write during reset
    extRstN = 1'b0;
    tick(); tick();
    clkMissing = 1'b1;
    regWrite(8'hEF, 8'h00);
    clkMissing = 1'b0;
    extRstN = 1'b1;
    waitRelease();
    regCheck("R3 flag held through reset", 8'hEF, 8'h01);
    cmpOut = 1'b0;
    tick(); tick();
    check("R9 write ignored, cmp still enabled", {7'b0, sysRst}, 8'h01);
    cmpOut = 1'b1;
    waitRelease();
    regCheck("R6 comparator flag", 8'hEF, 8'h20);

    // supply monitor gating
    regWrite(8'hEF, 8'h00);
    supplyLow = 1'b1;
    repeat (4) tick();
    check("R7 supply not selected", {7'b0, sysRst}, 8'h00);
    regCheck("R8 live status low", 8'hFF, 8'h80);
    regWrite(8'hFF, 8'h00);
    regWrite(8'hEF, 8'h02);
    repeat (4) tick();
    check("R7 monitor disabled", {7'b0, sysRst}, 8'h00);
    regWrite(8'hFF, 8'h80);
    tick();
    check("R7 monitor enabled and selected", {7'b0, sysRst}, 8'h01);
    supplyLow = 1'b0;
    waitRelease();
    regCheck("R7 supply flag", 8'hEF, 8'h02);

    // missing clock enable
    clkMissing = 1'b1;
    repeat (4) tick();
    check("R5 missing clock disabled", {7'b0, sysRst}, 8'h00);
    regWrite(8'hEF, 8'h04);
    tick();
    check("R5 missing clock enabled", {7'b0, sysRst}, 8'h01);
    clkMissing = 1'b0;
    waitRelease();
    regCheck("R5 missing clock flag", 8'hEF, 8'h04);

    // comparator not selected
    cmpOut = 1'b0;
    repeat (4) tick();
    check("R6 comparator ignored", {7'b0, sysRst}, 8'h00);
    cmpOut = 1'b1;

    // priority
    regWrite(8'hEF, 8'h26);
    extRstN = 1'b0; supplyLow = 1'b1; clkMissing = 1'b1; cmpOut = 1'b0;
    tick(); tick();
    extRstN = 1'b1; supplyLow = 1'b0; clkMissing = 1'b0; cmpOut = 1'b1;
    waitRelease();
    regCheck("R4 pin wins", 8'hEF, 8'h01);
    supplyLow = 1'b1; clkMissing = 1'b1; cmpOut = 1'b0;
    tick(); tick();
    supplyLow = 1'b0; clkMissing = 1'b0; cmpOut = 1'b1;
    waitRelease();
    regCheck("R4 supply wins", 8'hEF, 8'h02);
    clkMissing = 1'b1; cmpOut = 1'b0;
    tick(); tick();
    clkMissing = 1'b0; cmpOut = 1'b1;
    waitRelease();
    regCheck("R4 missing clock wins", 8'hEF, 8'h04);

    // power-on again clears enables
    porN = 1'b0;
    #1;
    check("R10 async POR", {7'b0, sysRst}, 8'h01);
    tick();
    porN = 1'b1;
    cmpOut = 1'b0;
    waitRelease();
    check("R10 enables cleared", {7'b0, sysRst}, 8'h00);
    repeat (4) tick();
    check("R10 comparator stays disabled", {7'b0, sysRst}, 8'h00);
    regCheck("R10 flags after second POR", 8'hEF, 8'h02);
    regCheck("R10 monitor enable after POR", 8'hFF, 8'hC0);
    cmpOut = 1'b1;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule